// File: doc/BRIEF.md
# Dual-Counter Performance Monitor Unit

This block counts hardware events for a processor core using two 32-bit counters. A small register port gives access to two 64-bit registers. One is a control register: it holds one event-select code per counter, three privilege-mode enables shared by both counters, and two overflow-interrupt enables. The other is a counter register that holds both counters side by side. Every cycle an abstract event bus presents one strobe per event code. Each counter follows the strobe chosen by its select code, and it counts only while the enable bit for the current privilege mode is set.

Software arms a sample period by loading a counter with the two's complement of the period. After that many events the counter wraps from all-ones to zero. The wrap latches an overflow flag, and the flag raises a level interrupt when its enable bit is set. Any write to the control register clears the flags, and with them the interrupt. The privilege-mode enables are shared by both counters, so a single counter cannot be switched off on its own. Instead, software parks it by selecting a reserved code that never fires.

Top module: `evmon`

## Requirements
- R1: Register select 1 gives the counter register. Bits 31:0 hold the lower counter and bits 63:32 the upper counter. One write loads both counters in the same cycle, and a read returns them in the same cycle. Both counters reset to zero.
- R2: A counter sets its overflow flag only when an increment takes it from 0xFFFFFFFF to 0. Reading at register select 0, the flag for the lower counter is bit 32 and the flag for the upper counter is bit 33. Loading a counter never sets a flag, whatever value is loaded.
- R3: Bits 17:6 of the control register select the event for the lower counter, and bits 30:19 select it for the upper counter. A counter increases by exactly one on each cycle in which event bus bit `code` is high. A code at or above the bus width never counts.
- R4: privMode 0 (user) counts only when bit 2 is set, 1 (supervisor) only when bit 1 is set, and 2 (hypervisor) only when bit 3 is set. privMode 3 never counts. The enables apply to both counters, so with all three bits clear neither counter moves.
- R5: Select code 0x220 parks a counter: it never counts, while the other counter goes on counting.
- R6: Any write to the control register clears both overflow flags from the next cycle. The exception is a wrap in the same cycle, which still sets its own flag.
- R7: ovfIrq is high exactly while the lower flag and control bit 4 are both set, or the upper flag and control bit 5 are both set.
- R8: Writing the counter register leaves the overflow flags and ovfIrq unchanged.
- R9: When a counter-register write and an event fall in the same cycle, the written value is loaded and the event is dropped.
- R10: The control register reads back bits 30:19, 17:6 and 5:1 as last written, together with the flags in bits 33:32. All other bits read zero, and the register resets to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Write strobe for the register chosen by regSel |
| regSel | input | 1 | 0 = control register, 1 = counter register |
| regWrData | input | 64 | Write data |
| regRdData | output | 64 | Read data of the register chosen by regSel (same cycle) |
| privMode | input | 2 | Current privilege mode: 0 user, 1 supervisor, 2 hypervisor, 3 none |
| eventBus | input | NUM_EVENTS | One event strobe per code, sampled every cycle |
| ovfIrq | output | 1 | Level overflow interrupt |

## Verification
Register writes, counter increments and overflow flags all take effect at the first rising edge after the stimulus. Read data and ovfIrq follow the stored state combinationally in the same cycle. The bench changes inputs at falling edges and holds an event for exactly as many rising edges as the pulses it expects to count. It then reads the results one falling edge later, so each sample sees the state exactly one register stage after the last stimulus. The collision cases (control write with a wrap, counter write with an event) are driven within a single cycle and checked on the following falling edge.

// File: rtl/evmon_pkg.sv
package evmon_pkg;
  localparam int CNT_W   = 32;
  localparam int NUM_CNT = 2;
  localparam int REG_W   = CNT_W * NUM_CNT;
  localparam int SEL_W   = 12;

  localparam int LO = 0;
  localparam int HI = 1;

  // Control register layout; the positions are decoded by software.
  localparam int EN_SUP_BIT = 1;
  localparam int EN_USR_BIT = 2;
  localparam int EN_HYP_BIT = 3;
  localparam int IE_LSB     = 4;
  localparam int SEL_LSB_LO = 6;
  localparam int SEL_LSB_HI = 19;
  localparam int FLAG_LSB   = 32;

  localparam logic [SEL_W-1:0] PARK_CODE = 12'h220;

  typedef enum logic [1:0] {
    MODE_USER = 2'd0,
    MODE_SUP  = 2'd1,
    MODE_HYP  = 2'd2,
    MODE_NONE = 2'd3
  } privMode_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic               load;
    logic [NUM_CNT-1:0] inc;
  } dpStrobe_t;

  function automatic int selLsb(input int idx);
    return (idx == HI) ? SEL_LSB_HI : SEL_LSB_LO;
  endfunction
endpackage

// File: rtl/evmon_datapath.sv
module evmon_datapath
  import evmon_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobe_t          strobe,
  input  logic [REG_W-1:0]   loadData,
  output logic [REG_W-1:0]   cntView,
  output logic [NUM_CNT-1:0] wrap
);
  for (genvar g = 0; g < NUM_CNT; g++) begin : gCnt
    logic [CNT_W-1:0] cntQ;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cntQ <= '0;
      end else if (strobe.load) begin
        cntQ <= loadData[g*CNT_W +: CNT_W];
      end else if (strobe.inc[g]) begin
        cntQ <= cntQ + 1'b1;
      end
    end

    // All-ones plus one: the only transition that counts as overflow.
    assign wrap[g] = strobe.inc[g] & (&cntQ);
    assign cntView[g*CNT_W +: CNT_W] = cntQ;
  end
endmodule

// File: rtl/evmon_ctrl.sv
module evmon_ctrl
  import evmon_pkg::*;
#(
  parameter int NUM_EVENTS = 64
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWrEn,
  input  logic                  regSel,
  input  logic [REG_W-1:0]      regWrData,
  input  logic [1:0]            privMode,
  input  logic [NUM_EVENTS-1:0] eventBus,
  input  logic [NUM_CNT-1:0]    wrap,
  output dpStrobe_t             strobe,
  output logic [REG_W-1:0]      ctrlView,
  output logic                  ovfIrq
);
  localparam int IDX_W = (NUM_EVENTS > 1) ? $clog2(NUM_EVENTS) : 1;

  logic               supEn;
  logic               usrEn;
  logic               hypEn;
  logic [NUM_CNT-1:0] irqEn;
  logic [NUM_CNT-1:0] ovfFlag;
  logic [SEL_W-1:0]   evSel [NUM_CNT];
  logic [NUM_CNT-1:0] evHit;
  logic               modeOk;
  logic               ctrlWr;
  logic               cntWr;

  assign ctrlWr = regWrEn & ~regSel;
  assign cntWr  = regWrEn & regSel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      supEn <= 1'b0;
      usrEn <= 1'b0;
      hypEn <= 1'b0;
      irqEn <= '0;
      for (int i = 0; i < NUM_CNT; i++) evSel[i] <= '0;
    end else if (ctrlWr) begin
      supEn <= regWrData[EN_SUP_BIT];
      usrEn <= regWrData[EN_USR_BIT];
      hypEn <= regWrData[EN_HYP_BIT];
      irqEn <= regWrData[IE_LSB +: NUM_CNT];
      for (int i = 0; i < NUM_CNT; i++) evSel[i] <= regWrData[selLsb(i) +: SEL_W];
    end
  end

  // A control write clears the flags; a wrap in the same cycle still sets its flag.
  always_ff @(posedge clk) begin
    if (!rstN) ovfFlag <= '0;
    else       ovfFlag <= (ctrlWr ? '0 : ovfFlag) | wrap;
  end

  always_comb begin
    unique case (privMode_e'(privMode))
      MODE_USER: modeOk = usrEn;
      MODE_SUP:  modeOk = supEn;
      MODE_HYP:  modeOk = hypEn;
      default:   modeOk = 1'b0;
    endcase
  end

  for (genvar g = 0; g < NUM_CNT; g++) begin : gSel
    always_comb begin
      if (evSel[g] == PARK_CODE || int'(evSel[g]) >= NUM_EVENTS) evHit[g] = 1'b0;
      else evHit[g] = eventBus[evSel[g][IDX_W-1:0]];
    end
  end

  assign strobe.load = cntWr;
  assign strobe.inc  = evHit & {NUM_CNT{modeOk & ~cntWr}};

  always_comb begin
    ctrlView = '0;
    ctrlView[EN_SUP_BIT] = supEn;
    ctrlView[EN_USR_BIT] = usrEn;
    ctrlView[EN_HYP_BIT] = hypEn;
    ctrlView[IE_LSB +: NUM_CNT] = irqEn;
    for (int i = 0; i < NUM_CNT; i++) ctrlView[selLsb(i) +: SEL_W] = evSel[i];
    ctrlView[FLAG_LSB +: NUM_CNT] = ovfFlag;
  end

  assign ovfIrq = |(ovfFlag & irqEn);

  logic unusedWrBits;
  assign unusedWrBits = ^{regWrData[REG_W-1:SEL_LSB_HI+SEL_W],
                          regWrData[SEL_LSB_LO+SEL_W], regWrData[0]};
endmodule

// File: rtl/evmon.sv
module evmon
  import evmon_pkg::*;
#(
  parameter int NUM_EVENTS = 64
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWrEn,
  input  logic                  regSel,
  input  logic [63:0]           regWrData,
  output logic [63:0]           regRdData,
  input  logic [1:0]            privMode,
  input  logic [NUM_EVENTS-1:0] eventBus,
  output logic                  ovfIrq
);
  dpStrobe_t          strobe;
  logic [REG_W-1:0]   ctrlView;
  logic [REG_W-1:0]   cntView;
  logic [NUM_CNT-1:0] wrap;

  evmon_ctrl #(.NUM_EVENTS(NUM_EVENTS)) uCtrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .privMode(privMode), .eventBus(eventBus),
    .wrap(wrap), .strobe(strobe), .ctrlView(ctrlView), .ovfIrq(ovfIrq)
  );

  evmon_datapath uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .loadData(regWrData),
    .cntView(cntView), .wrap(wrap)
  );

  assign regRdData = regSel ? cntView : ctrlView;
endmodule

// File: rtl/evmon_checker.sv
module evmon_checker #(
  parameter int NUM_EVENTS = 64
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  regWrEn,
  input logic                  regSel,
  input logic [63:0]           regWrData,
  input logic [1:0]            privMode,
  input logic [NUM_EVENTS-1:0] eventBus,
  input logic                  ovfIrq,
  input logic [63:0]           ctrlView,
  input logic [63:0]           cntView
);
  localparam int IDX_W = (NUM_EVENTS > 1) ? $clog2(NUM_EVENTS) : 1;

  logic        cntWr;
  logic        ctrlWr;
  logic        modeOk;
  logic        hitLo;
  logic [11:0] selLo;

  assign cntWr  = regWrEn & regSel;
  assign ctrlWr = regWrEn & ~regSel;
  assign selLo  = ctrlView[17:6];

  always_comb begin
    case (privMode)
      2'd0:    modeOk = ctrlView[2];
      2'd1:    modeOk = ctrlView[1];
      2'd2:    modeOk = ctrlView[3];
      default: modeOk = 1'b0;
    endcase
  end

  always_comb begin
    if (selLo == 12'h220 || int'(selLo) >= NUM_EVENTS) hitLo = 1'b0;
    else hitLo = eventBus[selLo[IDX_W-1:0]];
  end

  // R9: a counter write loads exactly the written value.
  p_load_wins_r9: assert property (@(posedge clk) disable iff (!rstN)
    cntWr |=> cntView == $past(regWrData));

  // R1: without a load the lower counter holds or steps by one.
  p_step_r1: assert property (@(posedge clk) disable iff (!rstN)
    !cntWr |=> (cntView[31:0] == $past(cntView[31:0])) ||
               (cntView[31:0] == $past(cntView[31:0]) + 32'd1));

  // R4: with the current mode disabled nothing counts.
  p_mode_gate_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!cntWr && !modeOk) |=> $stable(cntView));

  // R2: lower counter wrapping from all-ones sets its flag.
  p_wrap_flag_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!cntWr && modeOk && hitLo && cntView[31:0] == 32'hFFFF_FFFF) |=> ctrlView[32]);

  // R6: a control write with no possible wrap clears both flags.
  p_ctrl_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && cntView[31:0] != 32'hFFFF_FFFF && cntView[63:32] != 32'hFFFF_FFFF)
      |=> ctrlView[33:32] == 2'b00);

  // R7: no flag, no interrupt.
  p_quiet_irq_r7: assert property (@(posedge clk) disable iff (!rstN)
    ctrlView[33:32] == 2'b00 |-> !ovfIrq);

  // R5: a parked upper counter holds.
  p_park_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!cntWr && ctrlView[30:19] == 12'h220) |=> $stable(cntView[63:32]));

  // R8: a counter write leaves the flags alone.
  p_flags_kept_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cntWr && ctrlView[33:32] != 2'b00) |=> ctrlView[33:32] != 2'b00);
endmodule

bind evmon evmon_checker #(.NUM_EVENTS(NUM_EVENTS)) uChk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
  .regWrData(regWrData), .privMode(privMode), .eventBus(eventBus),
  .ovfIrq(ovfIrq), .ctrlView(ctrlView), .cntView(cntView)
);

// File: tb/evmon_test.sv
`timescale 1ns/1ps
module evmon_test;
  localparam int NUM_EVENTS = 64;

  logic                  clk = 1'b0;
  logic                  rstN = 1'b0;
  logic                  regWrEn = 1'b0;
  logic                  regSel = 1'b0;
  logic [63:0]           regWrData = '0;
  logic [63:0]           regRdData;
  logic [1:0]            privMode = 2'd0;
  logic [NUM_EVENTS-1:0] eventBus = '0;
  logic                  ovfIrq;

  int  checks = 0;
  int  failures = 0;
  bit  done = 1'b0;

  always #4 clk = ~clk;

  evmon #(.NUM_EVENTS(NUM_EVENTS)) uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .regRdData(regRdData), .privMode(privMode),
    .eventBus(eventBus), .ovfIrq(ovfIrq)
  );

  // Control word: upper select at 30:19, lower at 17:6, irq enables 5:4,
  // enables {hyp,usr,sup} at 3:1.
  function automatic logic [63:0] mkCtrl(input logic [11:0] hiSel, input logic [11:0] loSel,
                                         input logic [2:0] en, input logic [1:0] ie);
    return (64'(hiSel) << 19) | (64'(loSel) << 6) | (64'(ie) << 4) | (64'(en) << 1);
  endfunction

  typedef struct packed {
    logic [63:0] ctrl;
    logic [63:0] preset;
    logic [1:0]  mode;
    logic [63:0] events;
    logic [7:0]  pulses;
    logic [63:0] expCnt;
    logic [1:0]  expFlags;
    logic        expIrq;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    // R1/R3: both counters on their own codes
    '{mkCtrl(12'd3, 12'd5, 3'b010, 2'b00), 64'd0, 2'd0, 64'h28, 8'd4,
      {32'd4, 32'd4}, 2'b00, 1'b0, 8'd3},
    // R3: only the lower code fires
    '{mkCtrl(12'd3, 12'd5, 3'b010, 2'b00), {32'd10, 32'd20}, 2'd0, 64'h20, 8'd3,
      {32'd10, 32'd23}, 2'b00, 1'b0, 8'd3},
    // R4: user enable only, supervisor mode
    '{mkCtrl(12'd3, 12'd5, 3'b010, 2'b00), {32'd7, 32'd7}, 2'd1, 64'h28, 8'd5,
      {32'd7, 32'd7}, 2'b00, 1'b0, 8'd4},
    // R4: supervisor enable, supervisor mode
    '{mkCtrl(12'd3, 12'd5, 3'b001, 2'b00), 64'd0, 2'd1, 64'h28, 8'd2,
      {32'd2, 32'd2}, 2'b00, 1'b0, 8'd4},
    // R4: hypervisor enable, hypervisor mode
    '{mkCtrl(12'd3, 12'd5, 3'b100, 2'b00), 64'd0, 2'd2, 64'h28, 8'd1,
      {32'd1, 32'd1}, 2'b00, 1'b0, 8'd4},
    // R5: upper parked, lower counts
    '{mkCtrl(12'h220, 12'd5, 3'b111, 2'b00), 64'd0, 2'd0, {64{1'b1}}, 8'd6,
      {32'd0, 32'd6}, 2'b00, 1'b0, 8'd5},
    // R2/R7: lower wraps, lower irq enabled
    '{mkCtrl(12'h220, 12'd1, 3'b010, 2'b01), {32'd0, 32'hFFFF_FFFE}, 2'd0, 64'h2, 8'd3,
      {32'd0, 32'd1}, 2'b01, 1'b1, 8'd2},
    // R7: upper wraps but only lower irq enabled
    '{mkCtrl(12'd2, 12'h220, 3'b010, 2'b01), {32'hFFFF_FFFF, 32'd0}, 2'd0, 64'h4, 8'd1,
      {32'd0, 32'd0}, 2'b10, 1'b0, 8'd7},
    // R4: all enables clear stops both
    '{mkCtrl(12'd3, 12'd5, 3'b000, 2'b00), {32'd5, 32'd5}, 2'd0, {64{1'b1}}, 8'd4,
      {32'd5, 32'd5}, 2'b00, 1'b0, 8'd4},
    // R4: mode 3 never counts
    '{mkCtrl(12'd3, 12'd5, 3'b111, 2'b00), {32'd1, 32'd2}, 2'd3, 64'h28, 8'd4,
      {32'd1, 32'd2}, 2'b00, 1'b0, 8'd4},
    // R3: code above bus width never counts
    '{mkCtrl(12'd100, 12'd5, 3'b010, 2'b00), 64'd0, 2'd0, {64{1'b1}}, 8'd3,
      {32'd0, 32'd3}, 2'b00, 1'b0, 8'd3}
  };

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic writeReg(input logic sel, input logic [63:0] data);
    regSel = sel;
    regWrData = data;
    regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic readReg(input logic sel, output logic [63:0] data);
    regSel = sel;
    #1;
    data = regRdData;
  endtask

  task automatic pulse(input logic [NUM_EVENTS-1:0] ev, input int n);
    eventBus = ev;
    repeat (n) @(negedge clk);
    eventBus = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R1 watchdog actual=timeout expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [63:0] rd;
    logic [63:0] cfg;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // Reset state: R10, R1, R7
    readReg(1'b0, rd); check("R10 reset ctrl", rd, 64'd0);
    readReg(1'b1, rd); check("R1 reset counters", rd, 64'd0);
    check("R7 reset irq", {63'd0, ovfIrq}, 64'd0);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      writeReg(1'b0, VECS[i].ctrl);
      writeReg(1'b1, VECS[i].preset);
      privMode = VECS[i].mode;
      pulse(VECS[i].events[NUM_EVENTS-1:0], int'(VECS[i].pulses));
      readReg(1'b1, rd);
      check($sformatf("R%0d vec%0d counters", VECS[i].req, i), rd, VECS[i].expCnt);
      readReg(1'b0, rd);
      check($sformatf("R%0d vec%0d ctrl", VECS[i].req, i), rd,
            VECS[i].ctrl | (64'(VECS[i].expFlags) << 32));
      check($sformatf("R%0d vec%0d irq", VECS[i].req, i), {63'd0, ovfIrq},
            {63'd0, VECS[i].expIrq});
    end

    // R10: writable-bit mask
    writeReg(1'b0, {64{1'b1}});
    readReg(1'b0, rd);
    check("R10 readback mask", rd,
          (64'hFFF << 19) | (64'hFFF << 6) | (64'h1F << 1));

    // R9: counter write beats same-cycle event
    privMode = 2'd0;
    writeReg(1'b0, mkCtrl(12'h220, 12'd1, 3'b010, 2'b00));
    eventBus = 64'h2;
    writeReg(1'b1, {32'h50, 32'h40});
    readReg(1'b1, rd); check("R9 load over event", rd, {32'h50, 32'h40});
    @(negedge clk);
    eventBus = '0;
    readReg(1'b1, rd); check("R9 count after load", rd, {32'h50, 32'h41});

    // R6: wrap in the same cycle as a control write still sets the flag
    cfg = mkCtrl(12'h220, 12'd1, 3'b010, 2'b01);
    writeReg(1'b0, cfg);
    writeReg(1'b1, {32'd0, 32'hFFFF_FFFF});
    eventBus = 64'h2;
    writeReg(1'b0, cfg);
    eventBus = '0;
    readReg(1'b1, rd); check("R6 collision counter", rd, 64'd0);
    readReg(1'b0, rd); check("R6 collision flag set", {62'd0, rd[33:32]}, 64'd1);
    check("R7 collision irq", {63'd0, ovfIrq}, 64'd1);

    // R6: plain control write clears flag and irq
    writeReg(1'b0, cfg);
    readReg(1'b0, rd); check("R6 clear flags", {62'd0, rd[33:32]}, 64'd0);
    check("R6 clear irq", {63'd0, ovfIrq}, 64'd0);

    // R8: counter write keeps the flag
    writeReg(1'b1, {32'd0, 32'hFFFF_FFFF});
    pulse(64'h2, 1);
    writeReg(1'b1, {32'd0, 32'd5});
    readReg(1'b1, rd); check("R8 counter loaded", rd, {32'd0, 32'd5});
    readReg(1'b0, rd); check("R8 flag kept", {62'd0, rd[33:32]}, 64'd1);
    check("R8 irq kept", {63'd0, ovfIrq}, 64'd1);

    // R2: loads and a non-wrapping carry set no flag
    writeReg(1'b0, cfg);
    writeReg(1'b1, {64{1'b1}});
    writeReg(1'b1, 64'd0);
    readReg(1'b0, rd); check("R2 load no flag", {62'd0, rd[33:32]}, 64'd0);
    writeReg(1'b1, {32'd0, 32'h7FFF_FFFF});
    pulse(64'h2, 1);
    readReg(1'b1, rd); check("R2 carry counter", rd, {32'd0, 32'h8000_0000});
    readReg(1'b0, rd); check("R2 carry no flag", {62'd0, rd[33:32]}, 64'd0);
    check("R7 carry no irq", {63'd0, ovfIrq}, 64'd0);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule